// File: doc/BRIEF.md
# Dual-Clock Programmable Almost-Full / Almost-Empty Flag Generator

This block produces the two programmable threshold flags of a FIFO whose write and read sides run on unrelated clocks. It keeps a write pointer and a read pointer, each in its own clock domain. From these pointers it works out how many words the FIFO holds and compares that number with two offsets: a full offset `m` and an empty offset `n`. Both flags are active low. The storage array and the loading of the offsets are handled elsewhere, and the offsets are treated as static while traffic flows.

Two configuration pins are captured while master reset is held. The first one selects how the flags are timed:
- **Registered timing.** Each flag is a flop in a single domain. A flag is asserted on the edge of the clock that causes the crossing. Its release reaches the output only after the opposite pointer has passed through a Gray-code synchroniser.
- **Direct timing.** Each flag is decoded straight from the two pointer registers. A flag is therefore pulled low by one clock and released by the other, with no synchroniser delay.

The second pin selects fall-through operation. In that mode the effective depth is one word larger than the array, and the almost-empty threshold moves up by one word.

Top module: `almostFlagGen`

## Requirements
- R1: While master reset is held and right after it is released, `almostEmptyN` is 0 and `almostFullN` is 1, in both timing modes.
- R2: Once settled, `almostFullN` is 0 when the word count is at least D−m and 1 when the count is D−(m+1) or less. D is the effective depth.
- R3: In standard mode, once settled, `almostEmptyN` is 0 when the count is n or less and 1 when the count is n+1 or more.
- R4: When `fallThroughSel` was 1 at reset, D is ARRAY_DEPTH+1 and `almostEmptyN` stays 0 up to n+1 words. It rises at n+2 words.
- R5: `syncModeSel` and `fallThroughSel` are taken only while `rstN` is 0. Changing them after reset changes neither the flag timing nor the thresholds.
- R6: In registered mode (`syncModeSel`=1 at reset), `almostFullN` falls only on a `wrClk` edge that accepts a write. A read that drops the count below D−m raises the flag only after the read pointer has crossed into the write domain, never at the read edge itself.
- R7: In registered mode, `almostEmptyN` falls only on a `rdClk` edge that accepts a read. A write that lifts the count above the threshold raises the flag only after the write pointer has crossed into the read domain.
- R8: In direct mode (`syncModeSel`=0 at reset), `almostFullN` goes low right after the `wrClk` edge that reaches D−m words. It goes high right after the `rdClk` edge that leaves D−(m+1) words.
- R9: In direct mode, `almostEmptyN` goes low right after the `rdClk` edge that reaches the empty threshold. It goes high right after the `wrClk` edge that passes it.
- R10: A write presented while the FIFO holds D words is ignored, and a read presented while it holds zero words is ignored. Neither moves the count that the flags are based on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Master reset, active low, asynchronous to both clocks |
| syncModeSel | input | 1 | Timing mode, captured during reset: 1 registered, 0 direct |
| fallThroughSel | input | 1 | Fall-through mode, captured during reset: 1 selects it |
| wrEn | input | 1 | Write request, sampled on `wrClk` |
| rdEn | input | 1 | Read request, sampled on `rdClk` |
| fullOffset | input | PTR_W | Almost-full offset m |
| emptyOffset | input | PTR_W | Almost-empty offset n |
| almostFullN | output | 1 | Almost-full flag, active low |
| almostEmptyN | output | 1 | Almost-empty flag, active low |

## Verification
The bench builds the block with ARRAY_DEPTH=16 and SYNC_STAGES=2, so pointers are 6 bits wide. With these values the full and empty boundaries, including the 17-word fall-through depth, are reached within a few dozen writes. The two-stage crossing also keeps the release delay short enough to show it as a visible one-edge lag.

The write clock has a period of 10 and the read clock a period of 14. Their edges drift against each other, and they sometimes coincide. The offsets are picked so that both thresholds sit inside the range of counts that random traffic covers, in all four combinations of timing mode and fall-through mode.

// File: rtl/almostFlagPkg.sv
package almostFlagPkg;

  // Control-to-datapath strobes and latched configuration, one copy per domain.
  typedef struct packed {
    logic wrAdv;   // write accepted on this wrClk edge
    logic rdAdv;   // read accepted on this rdClk edge
    logic syncW;   // registered timing, write-domain copy
    logic syncR;   // registered timing, read-domain copy
    logic fwftW;   // fall-through, write-domain copy
    logic fwftR;   // fall-through, read-domain copy
  } flagStrobes_t;

endpackage

// File: rtl/cdcSync.sv
module cdcSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= dIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/flagCtrl.sv
module flagCtrl
  import almostFlagPkg::*;
#(
  parameter int ARRAY_DEPTH = 16,
  parameter int PTR_W       = 6
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             syncModeSel,
  input  logic             fallThroughSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [PTR_W-1:0] wrCount,
  input  logic [PTR_W-1:0] rdCount,
  output flagStrobes_t     strobes
);

  localparam logic [PTR_W-1:0] BASE_DEPTH = PTR_W'(ARRAY_DEPTH);

  logic syncW, fwftW, syncR, fwftR;
  logic [PTR_W-1:0] depthW;

  // Configuration is captured only while master reset is held.
  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      syncW <= syncModeSel;
      fwftW <= fallThroughSel;
    end
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      syncR <= syncModeSel;
      fwftR <= fallThroughSel;
    end
  end

  assign depthW = BASE_DEPTH + {{(PTR_W-1){1'b0}}, fwftW};

  always_comb begin
    strobes.syncW = syncW;
    strobes.syncR = syncR;
    strobes.fwftW = fwftW;
    strobes.fwftR = fwftR;
    strobes.wrAdv = wrEn && (wrCount < depthW);
    strobes.rdAdv = rdEn && (rdCount != '0);
  end

  // R5: latched mode does not move once reset is released
  p_mode_hold_w_r5 : assert property (@(posedge wrClk) disable iff (!rstN)
    $stable(syncW) && $stable(fwftW));
  p_mode_hold_r_r5 : assert property (@(posedge rdClk) disable iff (!rstN)
    $stable(syncR) && $stable(fwftR));

endmodule

// File: rtl/flagDatapath.sv
module flagDatapath
  import almostFlagPkg::*;
#(
  parameter int ARRAY_DEPTH = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 6
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  flagStrobes_t     strobes,
  input  logic [PTR_W-1:0] fullOffset,
  input  logic [PTR_W-1:0] emptyOffset,
  output logic [PTR_W-1:0] wrCount,
  output logic [PTR_W-1:0] rdCount,
  output logic             almostFullN,
  output logic             almostEmptyN
);

  localparam logic [PTR_W-1:0] BASE_DEPTH = PTR_W'(ARRAY_DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wrPtr, rdPtr, wrGray, rdGray;
  logic [PTR_W-1:0] wrGraySync, rdGraySync, wrSyncBin, rdSyncBin;
  logic [PTR_W-1:0] wrPtrNext, rdPtrNext, wCountNext, rCountNext, trueCount;
  logic [PTR_W-1:0] afThr, aeThr;
  logic             afSyncN, aeSyncN, afDirectN, aeDirectN;

  assign afThr = BASE_DEPTH + {{(PTR_W-1){1'b0}}, strobes.fwftW} - fullOffset;
  assign aeThr = emptyOffset + {{(PTR_W-1){1'b0}}, strobes.fwftR};

  // Pointer crossings
  cdcSync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) i_rdToWr (
    .clk(wrClk), .rstN(rstN), .dIn(rdGray), .dOut(rdGraySync));
  cdcSync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) i_wrToRd (
    .clk(rdClk), .rstN(rstN), .dIn(wrGray), .dOut(wrGraySync));

  assign rdSyncBin = fromGray(rdGraySync);
  assign wrSyncBin = fromGray(wrGraySync);

  // Write domain
  assign wrPtrNext  = wrPtr + {{(PTR_W-1){1'b0}}, strobes.wrAdv};
  assign wrCount    = wrPtr - rdSyncBin;
  assign wCountNext = wrPtrNext - rdSyncBin;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrGray  <= '0;
      afSyncN <= 1'b1;
    end else begin
      wrPtr   <= wrPtrNext;
      wrGray  <= toGray(wrPtrNext);
      afSyncN <= !(wCountNext >= afThr);
    end
  end

  // Read domain
  assign rdPtrNext  = rdPtr + {{(PTR_W-1){1'b0}}, strobes.rdAdv};
  assign rdCount    = wrSyncBin - rdPtr;
  assign rCountNext = wrSyncBin - rdPtrNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      rdGray  <= '0;
      aeSyncN <= 1'b0;
    end else begin
      rdPtr   <= rdPtrNext;
      rdGray  <= toGray(rdPtrNext);
      aeSyncN <= !(rCountNext <= aeThr);
    end
  end

  // Direct timing: decoded from both pointer registers
  assign trueCount = wrPtr - rdPtr;
  assign afDirectN = !(trueCount >= afThr);
  assign aeDirectN = !(trueCount <= aeThr);

  assign almostFullN  = strobes.syncW ? afSyncN : afDirectN;
  assign almostEmptyN = strobes.syncR ? aeSyncN : aeDirectN;

  // R6: registered almost-full only falls on an accepted write
  p_af_fall_on_write_r6 : assert property (@(posedge wrClk) disable iff (!rstN)
    (strobes.syncW && $fell(afSyncN)) |-> $past(strobes.wrAdv));
  // R7: registered almost-empty only falls on an accepted read
  p_ae_fall_on_read_r7 : assert property (@(posedge rdClk) disable iff (!rstN)
    (strobes.syncR && $fell(aeSyncN)) |-> $past(strobes.rdAdv));
  // R10: write-side occupancy never exceeds the effective depth
  p_no_overflow_r10 : assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= BASE_DEPTH + {{(PTR_W-1){1'b0}}, strobes.fwftW});
  // R10: read-side occupancy never wraps past empty
  p_no_underflow_r10 : assert property (@(posedge rdClk) disable iff (!rstN)
    rdCount <= BASE_DEPTH + {{(PTR_W-1){1'b0}}, strobes.fwftR});

endmodule

// File: rtl/almostFlagGen.sv
module almostFlagGen
  import almostFlagPkg::*;
#(
  parameter int  ARRAY_DEPTH = 16,
  parameter int  SYNC_STAGES = 2,
  localparam int PTR_W       = $clog2(ARRAY_DEPTH + 1) + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             syncModeSel,
  input  logic             fallThroughSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [PTR_W-1:0] fullOffset,
  input  logic [PTR_W-1:0] emptyOffset,
  output logic             almostFullN,
  output logic             almostEmptyN
);

  flagStrobes_t     strobes;
  logic [PTR_W-1:0] wrCount, rdCount;

  flagCtrl #(.ARRAY_DEPTH(ARRAY_DEPTH), .PTR_W(PTR_W)) i_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .syncModeSel(syncModeSel), .fallThroughSel(fallThroughSel),
    .wrEn(wrEn), .rdEn(rdEn), .wrCount(wrCount), .rdCount(rdCount),
    .strobes(strobes));

  flagDatapath #(.ARRAY_DEPTH(ARRAY_DEPTH), .SYNC_STAGES(SYNC_STAGES), .PTR_W(PTR_W)) i_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .fullOffset(fullOffset), .emptyOffset(emptyOffset),
    .wrCount(wrCount), .rdCount(rdCount),
    .almostFullN(almostFullN), .almostEmptyN(almostEmptyN));

endmodule

// File: tb/test_almostFlagGen.sv
module test_almostFlagGen;

  localparam int WR_PERIOD   = 10;
  localparam int RD_PERIOD   = 14;
  localparam int ARRAY_DEPTH = 16;
  localparam int PTR_W       = $clog2(ARRAY_DEPTH + 1) + 1;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic syncPin = 1, fwftPin = 0, wrEn = 0, rdEn = 0;
  logic [PTR_W-1:0] fullOffset = 6, emptyOffset = 5;
  logic afN, aeN;

  int nChecks = 0, nFail = 0, contChecks = 0, contFails = 0;
  int wrDone = 0, rdDone = 0;
  int curSync = 1, curFwft = 0, curM = 6, curN = 5;
  bit chkOn = 0;

  always #(WR_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2) rdClk = ~rdClk;

  almostFlagGen #(.ARRAY_DEPTH(ARRAY_DEPTH), .SYNC_STAGES(2)) i_almostFlagGen (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .syncModeSel(syncPin), .fallThroughSel(fwftPin),
    .wrEn(wrEn), .rdEn(rdEn), .fullOffset(fullOffset), .emptyOffset(emptyOffset),
    .almostFullN(afN), .almostEmptyN(aeN));

  function automatic int depthNow();
    return ARRAY_DEPTH + curFwft;
  endfunction
  function automatic int occ();
    return wrDone - rdDone;
  endfunction
  function automatic logic expAf(int cnt);
    return (cnt >= depthNow() - curM) ? 1'b0 : 1'b1;
  endfunction
  function automatic logic expAe(int cnt);
    return (cnt <= curN + curFwft) ? 1'b0 : 1'b1;
  endfunction

  // Reference occupancy: accepted writes and reads (R10 limits)
  always @(posedge wrClk or negedge rstN)
    if (!rstN) wrDone <= 0;
    else if (wrEn && (wrDone - rdDone) < depthNow()) wrDone <= wrDone + 1;
  always @(posedge rdClk or negedge rstN)
    if (!rstN) rdDone <= 0;
    else if (rdEn && (wrDone - rdDone) > 0) rdDone <= rdDone + 1;

  // Continuous checks, away from the active edges
  always @(negedge wrClk or negedge rdClk) begin
    if (chkOn && rstN) begin
      int c;
      c = occ();
      if (curSync != 0) begin
        contChecks += 2;
        if (expAf(c) == 1'b0 && afN !== 1'b0) begin
          contFails++;
          $display("FAIL R6 count %0d: almostFullN actual %b expected 0", c, afN);
        end
        if (expAe(c) == 1'b0 && aeN !== 1'b0) begin
          contFails++;
          $display("FAIL R7 count %0d: almostEmptyN actual %b expected 0", c, aeN);
        end
      end else begin
        contChecks += 2;
        if (afN !== expAf(c)) begin
          contFails++;
          $display("FAIL R8 count %0d: almostFullN actual %b expected %b", c, afN, expAf(c));
        end
        if (aeN !== expAe(c)) begin
          contFails++;
          $display("FAIL R9 count %0d: almostEmptyN actual %b expected %b", c, aeN, expAe(c));
        end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b (count %0d)", req, act, exp, occ());
    end
  endtask

  task automatic doReset(input int s, input int f, input int m, input int n);
    chkOn = 0; rstN = 0; wrEn = 0; rdEn = 0;
    syncPin = s[0]; fwftPin = f[0];
    fullOffset = PTR_W'(m); emptyOffset = PTR_W'(n);
    curSync = s; curFwft = f; curM = m; curN = n;
    repeat (3) @(negedge rdClk);
    rstN = 1;
    @(negedge wrClk);
    chkOn = 1;
  endtask

  task automatic wrN(input int k);
    @(negedge wrClk); wrEn = 1;
    repeat (k) @(negedge wrClk);
    wrEn = 0;
  endtask

  task automatic rdN(input int k);
    @(negedge rdClk); rdEn = 1;
    repeat (k) @(negedge rdClk);
    rdEn = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  task automatic settledCheck(input string tag);
    settle();
    check({tag, " almostFull"}, afN, expAf(occ()));
    check({tag, " almostEmpty"}, aeN, expAe(occ()));
  endtask

  task automatic wrRandom(input int cycles, input int hiLim);
    for (int i = 0; i < cycles; i++) begin
      @(negedge wrClk);
      wrEn = (($urandom % 3) != 0) && (occ() < hiLim);
    end
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic rdRandom(input int cycles, input int loLim);
    for (int i = 0; i < cycles; i++) begin
      @(negedge rdClk);
      rdEn = (($urandom % 2) != 0) && (occ() > loLim);
    end
    @(negedge rdClk); rdEn = 0;
  endtask

  initial begin
    int seedInit;
    seedInit = $urandom(32'h5EED_0042);

    // ---- registered timing, standard: D=16, m=6 (threshold 10), n=5
    doReset(1, 0, 6, 5);
    check("R1 reset almostFull", afN, 1'b1);
    check("R1 reset almostEmpty", aeN, 1'b0);

    wrN(5); settle();
    check("R3 at n words", aeN, 1'b0);
    wrN(1); settle();
    check("R3 at n+1 words", aeN, 1'b1);
    rdN(1);
    check("R7 fall on read edge", aeN, 1'b0);
    wrN(1);
    check("R7 release waits for crossing", aeN, 1'b0);
    settle();
    check("R7 release after crossing", aeN, 1'b1);

    wrN(3); settle();
    check("R2 at D-(m+1)", afN, 1'b1);
    wrN(1);
    check("R6 fall on write edge", afN, 1'b0);
    rdN(1);
    check("R6 release waits for crossing", afN, 1'b0);
    settle();
    check("R2 back to D-(m+1)", afN, 1'b1);

    // R10 overflow: 10 requests from 9 words, only 7 fit
    wrN(10); settle();
    check("R10 full count", afN, 1'b0);
    rdN(7); settle();
    check("R10 extra writes ignored", afN, 1'b1);
    // R10 underflow: 12 requests from 9 words, only 9 taken
    rdN(12); settle();
    wrN(6); settle();
    check("R10 extra reads ignored", aeN, 1'b1);

    // R5: pins changed after reset have no effect
    syncPin = 0; fwftPin = 1;
    wrN(4);
    check("R5 still registered fall", afN, 1'b0);
    rdN(1);
    check("R5 still registered release delay", afN, 1'b0);
    rdN(3); settle();
    check("R5 empty threshold unchanged", aeN, 1'b1);
    settledCheck("R5");

    // ---- direct timing, fall-through: D=17, m=6 (threshold 11), n=5 (threshold 6)
    doReset(0, 1, 6, 5);
    check("R1 direct reset almostFull", afN, 1'b1);
    check("R1 direct reset almostEmpty", aeN, 1'b0);
    wrN(6);
    check("R4 at n+1 words", aeN, 1'b0);
    wrN(1);
    check("R9 release on write edge", aeN, 1'b1);
    rdN(1);
    check("R9 fall on read edge", aeN, 1'b0);
    wrN(4);
    check("R8 below threshold", afN, 1'b1);
    wrN(1);
    check("R8 fall on write edge", afN, 1'b0);
    rdN(1);
    check("R8 release on read edge", afN, 1'b1);
    wrN(20); settle();
    rdN(6);
    check("R4 depth 17 keeps flag", afN, 1'b0);
    rdN(1);
    check("R4 depth 17 release", afN, 1'b1);

    // ---- random traffic in all four configurations
    for (int cfg = 0; cfg < 4; cfg++) begin
      int m, n, d;
      m = 5 + int'($urandom % 3);
      n = 4 + int'($urandom % 4);
      doReset(cfg % 2, cfg / 2, m, n);
      d = depthNow();
      fork
        wrRandom(400, d - 5);
        rdRandom(300, 5);
      join
      settledCheck(cfg % 2 == 1 ? "R2 R3 random registered" : "R2 R3 random direct");
      rdN(d); settle();
      check("R1 R3 drained", aeN, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks + contChecks, nFail + contFails);
    $finish;
  end

  initial begin
    #(WR_PERIOD * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             nChecks + contChecks + 1, nFail + contFails + 1);
    $finish;
  end

endmodule